// File: doc/BRIEF.md
# Registered DIMM Control Word Sequencer

This block programs the register control words of the registered DDR3 modules on one memory channel, without firmware stepping through each write. It walks the chip selects two at a time, and for every populated pair it places a chip-select number and a two-bit target mask on its outputs. It then issues a run of control-word writes. Each write packs a 4-bit word number and a 4-bit value onto the three bank lines and the low address lines. It then raises a send flag that a downstream command issuer clears once the command has gone out.

A full initialization pass waits through a startup period and a PLL-lock period. It then sends words 0 to 15 in ascending order for each pair, leaving out the reserved words 6 and 7, with a mode-register delay before every word. It ends with a stabilization wait. Some values are fixed, some come from per-module stored values, one comes from the supply voltage code, and word 9 depends on the rank mix and the power-down policy. A frequency-change pass sends only word 10, carrying a code for the new speed grade, after one delay per populated pair. All waits are parameters counted in clock cycles.

The control state machine has the states IDLE, BOOT_WAIT, PLL_WAIT, SCAN, MRD_WAIT, ISSUE, HOLD, STAB_WAIT and FINISH. Its transitions are:
- IDLE to BOOT_WAIT on an initialization start.
- IDLE to SCAN on a frequency start with a known speed, or IDLE to FINISH when the speed is not known.
- BOOT_WAIT to PLL_WAIT, and PLL_WAIT to SCAN, each when its count runs out.
- SCAN to MRD_WAIT on a populated pair, SCAN to SCAN past an empty pair, and SCAN to STAB_WAIT or FINISH after the last pair.
- MRD_WAIT to ISSUE when the delay expires, ISSUE to HOLD, and HOLD to MRD_WAIT or SCAN once the issuer clears the flag.
- STAB_WAIT to FINISH, and FINISH to IDLE.

Top module: `rdimm_cw_seq`

## Requirements
- R1: Chip selects are taken in pairs (0/1, 2/3, ...), lowest pair first. A pair is served only if at least one of its two presence bits is set. While a pair at chip select c is served, `cs_sel` equals c and `cs_mask` equals 3 shifted left by c.
- R2: An initialization pass sends, per served pair, the words 0,1,2,3,4,5,8,9,10,11,12,13,14,15 in that order. Words 6 and 7 are never sent.
- R3: A write of word n with value d drives `bank` = {n[3], d[3], d[2]}, `addr[4:3]` = d[1:0] and `addr[2:0]` = n[2:0]. Every other address bit is 0.
- R4: `send_flag` rises to start a write and stays high, with `bank` and `addr` unchanged, until `issuer_clr` is seen high. It then drops on the next clock, and the sequencer does not move on before that.
- R5: In an initialization pass:
  - word 0 carries 0x2;
  - word 1 carries 0xC when the module (index = chip select shifted right by one) is single rank, and 0 otherwise;
  - words 2, 3, 4, 5 and 8 carry the module's stored slots 0, 1, 2, 3 and 4 of `dimm_words` (slot s of module m at bits [(m*5+s)*4 +: 4]);
  - word 11 carries `vdd_code`;
  - words 10, 12, 13, 14 and 15 carry 0.
- R6: Word 9 carries 0x9 when `pd_mode` equals 1, the module is single rank, and any module on the channel is dual rank or quad rank. Otherwise it carries 0xD.
- R7: A frequency-change pass sends only word 10, once per served pair, with value 0, 1, 2, 3 or 4 for `speed_grade` 800, 1066, 1333, 1600 or 1866.
- R8: A frequency-change start with any other `speed_grade` sets `speed_err`, sends nothing and finishes. `speed_err` is cleared by the next accepted start.
- R9: The initialization pass waits T_START then T_PLL cycles before the first pair. Every write is preceded by T_MRD cycles. After the last pair the pass waits T_STAB cycles. Each examined pair costs one scan cycle.
- R10: `busy` is high from the clock after an accepted start until the pass ends. `done` is high for exactly one cycle at the end. Start requests that arrive while busy are ignored.
- R11: After reset the block is idle, with `busy`, `done`, `send_flag`, `speed_err`, `bank`, `addr`, `cs_sel` and `cs_mask` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_init | input | 1 | Start an initialization pass (wins over start_freq) |
| start_freq | input | 1 | Start a frequency-change pass |
| cs_present | input | NUM_CS | Chip-select presence mask |
| dimm_sr | input | NUM_CS/2 | Per-module single-rank flags |
| dimm_dr | input | NUM_CS/2 | Per-module dual-rank flags |
| dimm_qr | input | NUM_CS/2 | Per-module quad-rank flags |
| pd_mode | input | 2 | Power-down policy setting |
| vdd_code | input | 4 | Encoded supply voltage |
| speed_grade | input | 12 | Target data rate in MT/s |
| dimm_words | input | NUM_CS/2*20 | Five stored 4-bit values per module |
| issuer_clr | input | 1 | Issuer has sent the pending word |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| speed_err | output | 1 | Last frequency start had an unknown speed |
| cs_sel | output | $clog2(NUM_CS) | First chip select of the served pair |
| cs_mask | output | NUM_CS | Target chip-select mask |
| bank | output | 3 | Bank lines of the pending write |
| addr | output | ADDR_W | Address lines of the pending write |
| send_flag | output | 1 | Write pending at the issuer |

## Verification
The assertions take for granted three things about the inputs:
- the presence mask, rank flags, stored values and speed grade are held steady for the whole of a pass;
- `issuer_clr` is raised only while `send_flag` is high;
- start requests are single-cycle pulses.

The stimulus changes configuration only between passes, while the block is idle. Its issuer model pulses the clear for one cycle after a varying latency of zero to two cycles, and its only start during a pass is a deliberate extra pulse aimed at the ignore rule.

// File: rtl/rdimm_cw_pkg.sv
package rdimm_cw_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_BOOT, S_PLL, S_SCAN, S_MRD, S_ISSUE, S_HOLD, S_STAB, S_DONE
    } seq_state_t;

    localparam logic [3:0] WORD_SPEED = 4'd10;
    localparam logic [3:0] WORD_LAST  = 4'd15;

    // {known, code[2:0]} for a data rate in MT/s
    function automatic logic [3:0] speed_decode(input logic [11:0] mts);
        case (mts)
            12'd800:  speed_decode = 4'b1_000;
            12'd1066: speed_decode = 4'b1_001;
            12'd1333: speed_decode = 4'b1_010;
            12'd1600: speed_decode = 4'b1_011;
            12'd1866: speed_decode = 4'b1_100;
            default:  speed_decode = 4'b0_000;
        endcase
    endfunction

    // step through the initialization word order, hopping the reserved pair
    function automatic logic [3:0] next_word(input logic [3:0] w);
        next_word = (w == 4'd5) ? 4'd8 : w + 4'd1;
    endfunction

endpackage

// File: rtl/rdimm_cw_value.sv
module rdimm_cw_value #(
    parameter int NUM_DIMM = 4,
    parameter int DIMM_W   = 2
) (
    input  logic [3:0]            word,
    input  logic                  freq_mode,
    input  logic [DIMM_W-1:0]     dimm,
    input  logic [NUM_DIMM-1:0]   dimm_sr,
    input  logic [NUM_DIMM-1:0]   dimm_dr,
    input  logic [NUM_DIMM-1:0]   dimm_qr,
    input  logic [1:0]            pd_mode,
    input  logic [3:0]            vdd_code,
    input  logic [NUM_DIMM*20-1:0] dimm_words,
    input  logic [2:0]            speed_code,
    output logic [3:0]            value
);
    logic [2:0] slot;
    logic [3:0] stored;
    logic       single;
    logic       multi_on_channel;

    assign single           = dimm_sr[dimm];
    assign multi_on_channel = (|dimm_dr) || (|dimm_qr);

    always_comb begin
        slot = 3'd0;
        if (word == 4'd8)                       slot = 3'd4;
        else if (word >= 4'd2 && word <= 4'd5)  slot = 3'(word - 4'd2);
    end

    assign stored = dimm_words[(int'(dimm) * 5 + int'(slot)) * 4 +: 4];

    always_comb begin
        value = 4'h0;
        if (freq_mode) begin
            value = {1'b0, speed_code};
        end else begin
            unique case (word)
                4'd0:                    value = 4'h2;
                4'd1:                    value = single ? 4'hC : 4'h0;
                4'd2, 4'd3, 4'd4, 4'd5,
                4'd8:                    value = stored;
                4'd9:                    value = (pd_mode == 2'd1 && single && multi_on_channel)
                                                 ? 4'h9 : 4'hD;
                4'd11:                   value = vdd_code;
                default:                 value = 4'h0;
            endcase
        end
    end
endmodule

// File: rtl/rdimm_cw_encode.sv
module rdimm_cw_encode #(
    parameter int ADDR_W = 16
) (
    input  logic [3:0]        word,
    input  logic [3:0]        value,
    output logic [2:0]        bank,
    output logic [ADDR_W-1:0] addr
);
    assign bank = {word[3], value[3:2]};
    assign addr = ADDR_W'({value[1:0], word[2:0]});
endmodule

// File: rtl/rdimm_cw_seq.sv
module rdimm_cw_seq
    import rdimm_cw_pkg::*;
#(
    parameter int NUM_CS  = 8,
    parameter int ADDR_W  = 16,
    parameter int T_START = 8,
    parameter int T_PLL   = 6,
    parameter int T_MRD   = 8,
    parameter int T_STAB  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_init,
    input  logic                      start_freq,
    input  logic [NUM_CS-1:0]         cs_present,
    input  logic [NUM_CS/2-1:0]       dimm_sr,
    input  logic [NUM_CS/2-1:0]       dimm_dr,
    input  logic [NUM_CS/2-1:0]       dimm_qr,
    input  logic [1:0]                pd_mode,
    input  logic [3:0]                vdd_code,
    input  logic [11:0]               speed_grade,
    input  logic [NUM_CS/2*20-1:0]    dimm_words,
    input  logic                      issuer_clr,
    output logic                      busy,
    output logic                      done,
    output logic                      speed_err,
    output logic [$clog2(NUM_CS)-1:0] cs_sel,
    output logic [NUM_CS-1:0]         cs_mask,
    output logic [2:0]                bank,
    output logic [ADDR_W-1:0]         addr,
    output logic                      send_flag
);
    localparam int NUM_PAIRS = NUM_CS / 2;
    localparam int PAIR_W    = $clog2(NUM_PAIRS + 1);
    localparam int DIMM_W    = $clog2(NUM_PAIRS);
    localparam int CS_W      = $clog2(NUM_CS);
    localparam int T_A       = (T_START > T_PLL) ? T_START : T_PLL;
    localparam int T_B       = (T_MRD > T_STAB) ? T_MRD : T_STAB;
    localparam int T_MAX     = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W     = $clog2(T_MAX + 1);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [PAIR_W-1:0] pair_q;
    logic [3:0]        word_q;
    logic              freq_q;
    logic [NUM_PAIRS:0] pair_occ;
    logic [3:0]        spd;
    logic              speed_ok, cnt_zero, pair_end;
    logic [3:0]        cw_value;
    logic [2:0]        enc_bank;
    logic [ADDR_W-1:0] enc_addr;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PAIRS; gi++) begin : g_occ
            assign pair_occ[gi] = |cs_present[2*gi +: 2];
        end
    endgenerate
    assign pair_occ[NUM_PAIRS] = 1'b0;

    assign spd      = speed_decode(speed_grade);
    assign speed_ok = spd[3];
    assign cnt_zero = (cnt_q == '0);
    assign pair_end = (pair_q == PAIR_W'(NUM_PAIRS));

    rdimm_cw_value #(.NUM_DIMM(NUM_PAIRS), .DIMM_W(DIMM_W)) u_value (
        .word(word_q), .freq_mode(freq_q), .dimm(pair_q[DIMM_W-1:0]),
        .dimm_sr(dimm_sr), .dimm_dr(dimm_dr), .dimm_qr(dimm_qr),
        .pd_mode(pd_mode), .vdd_code(vdd_code), .dimm_words(dimm_words),
        .speed_code(spd[2:0]), .value(cw_value)
    );

    rdimm_cw_encode #(.ADDR_W(ADDR_W)) u_encode (
        .word(word_q), .value(cw_value), .bank(enc_bank), .addr(enc_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_init)      state_d = S_BOOT;
                     else if (start_freq) state_d = speed_ok ? S_SCAN : S_DONE;
            S_BOOT:  if (cnt_zero) state_d = S_PLL;
            S_PLL:   if (cnt_zero) state_d = S_SCAN;
            S_SCAN:  if (pair_end)              state_d = freq_q ? S_DONE : S_STAB;
                     else if (pair_occ[pair_q]) state_d = S_MRD;
            S_MRD:   if (cnt_zero) state_d = S_ISSUE;
            S_ISSUE: state_d = S_HOLD;
            S_HOLD:  if (issuer_clr)
                         state_d = (freq_q || word_q == WORD_LAST) ? S_SCAN : S_MRD;
            S_STAB:  if (cnt_zero) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pair_q    <= '0;
            word_q    <= '0;
            freq_q    <= 1'b0;
            speed_err <= 1'b0;
            cs_sel    <= '0;
            cs_mask   <= '0;
            bank      <= '0;
            addr      <= '0;
            send_flag <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    pair_q <= '0;
                    if (start_init) begin
                        freq_q    <= 1'b0;
                        speed_err <= 1'b0;
                        cnt_q     <= CNT_W'(T_START - 1);
                    end else if (start_freq) begin
                        freq_q    <= 1'b1;
                        speed_err <= !speed_ok;
                    end
                end
                S_BOOT: cnt_q <= cnt_zero ? CNT_W'(T_PLL - 1) : cnt_q - 1'b1;
                S_PLL, S_MRD, S_STAB: if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
                S_SCAN: begin
                    if (pair_end) begin
                        cnt_q <= CNT_W'(T_STAB - 1);
                    end else if (pair_occ[pair_q]) begin
                        cs_sel  <= CS_W'({pair_q, 1'b0});
                        cs_mask <= NUM_CS'(2'b11) << {pair_q, 1'b0};
                        word_q  <= freq_q ? WORD_SPEED : 4'd0;
                        cnt_q   <= CNT_W'(T_MRD - 1);
                    end else begin
                        pair_q <= pair_q + 1'b1;
                    end
                end
                S_ISSUE: begin
                    bank      <= enc_bank;
                    addr      <= enc_addr;
                    send_flag <= 1'b1;
                end
                S_HOLD: if (issuer_clr) begin
                    send_flag <= 1'b0;
                    if (freq_q || word_q == WORD_LAST) begin
                        pair_q <= pair_q + 1'b1;
                    end else begin
                        word_q <= next_word(word_q);
                        cnt_q  <= CNT_W'(T_MRD - 1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != S_IDLE);
    assign done = (state_q == S_DONE);

    // R4: a pending write keeps its lines until the issuer clears it
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        send_flag && !issuer_clr |=> send_flag && $stable(bank) && $stable(addr));

    // R1: the target mask always covers a present chip select
    p_mask_present_r1: assert property (@(posedge clk) disable iff (!rst_n)
        send_flag |-> (cs_mask & cs_present) != '0 && $countones(cs_mask) == 2);

    // R2: reserved words never leave the block
    p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        send_flag |-> {bank[2], addr[2:0]} != 4'd6 && {bank[2], addr[2:0]} != 4'd7);

    // R3: address bits above the packed fields stay clear
    p_addr_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        send_flag |-> (addr >> 5) == '0);

    // R7: a frequency pass only ever sends the speed word
    p_freq_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        send_flag && freq_q |-> {bank[2], addr[2:0]} == WORD_SPEED);

    // R8: an unknown speed produces no write
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        speed_err |-> !send_flag);

    // R10: done lasts a single cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/rdimm_cw_seq_tb_top.sv
module rdimm_cw_seq_tb_top;
    localparam int NUM_CS = 8;
    localparam int NP     = NUM_CS / 2;
    localparam int ADDR_W = 16;
    localparam int TS = 5, TP = 3, TM = 4, TB = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_init = 1'b0, start_freq = 1'b0, issuer_clr = 1'b0;
    logic [NUM_CS-1:0] cs_present = '0;
    logic [NP-1:0] dimm_sr = '0, dimm_dr = '0, dimm_qr = '0;
    logic [1:0] pd_mode = '0;
    logic [3:0] vdd_code = '0;
    logic [11:0] speed_grade = 12'd800;
    logic [NP*20-1:0] dimm_words;
    logic busy, done, speed_err, send_flag;
    logic [2:0] cs_sel;
    logic [NUM_CS-1:0] cs_mask;
    logic [2:0] bank;
    logic [ADDR_W-1:0] addr;

    int checks = 0, errors = 0;
    int stv [NP][5];
    bit finished = 0;

    always #5 clk = ~clk;

    rdimm_cw_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .T_START(TS), .T_PLL(TP),
                   .T_MRD(TM), .T_STAB(TB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_init(start_init), .start_freq(start_freq),
        .cs_present(cs_present), .dimm_sr(dimm_sr), .dimm_dr(dimm_dr), .dimm_qr(dimm_qr),
        .pd_mode(pd_mode), .vdd_code(vdd_code), .speed_grade(speed_grade),
        .dimm_words(dimm_words), .issuer_clr(issuer_clr), .busy(busy), .done(done),
        .speed_err(speed_err), .cs_sel(cs_sel), .cs_mask(cs_mask), .bank(bank),
        .addr(addr), .send_flag(send_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int speed_code(input int mts);
        case (mts)
            800: return 0; 1066: return 1; 1333: return 2;
            1600: return 3; 1866: return 4; default: return -1;
        endcase
    endfunction

    function automatic int ref_value(input int n, input int d);
        case (n)
            0: return 2;
            1: return dimm_sr[d] ? 12 : 0;
            2, 3, 4, 5: return stv[d][n-2];
            8: return stv[d][4];
            9: return (pd_mode == 2'd1 && dimm_sr[d] && (dimm_dr != 0 || dimm_qr != 0)) ? 9 : 13;
            11: return int'(vdd_code);
            default: return 0;
        endcase
    endfunction

    // one pass compared against the behavioural model, cycle by cycle
    task automatic run_pass(input bit freq, input bit poke);
        int ep[$]; int en[$]; int ev[$];
        int gcnt, p_prev, g, dg, sc;
        bit bad;
        sc  = speed_code(int'(speed_grade));
        bad = freq && sc < 0;
        if (!bad)
            for (int p = 0; p < NP; p++)
                if (cs_present[2*p +: 2] != 0) begin
                    if (freq) begin ep.push_back(p); en.push_back(10); ev.push_back(sc); end
                    else for (int n = 0; n < 16; n++)
                        if (n != 6 && n != 7) begin
                            ep.push_back(p); en.push_back(n); ev.push_back(ref_value(n, p));
                        end
                end
        @(negedge clk);
        if (freq) start_freq = 1'b1; else start_init = 1'b1;
        @(negedge clk);
        start_freq = 1'b0; start_init = 1'b0; gcnt = 1;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        if (poke) begin
            start_init = 1'b1;
            @(negedge clk);
            start_init = 1'b0; gcnt = 2;
        end
        p_prev = -1;
        foreach (ep[i]) begin
            g = ((i == 0 && !freq) ? TS + TP : 0) + (ep[i] - p_prev) + TM + 1 + ((i == 0) ? 1 : 0);
            while (!send_flag && gcnt < 3000) begin @(negedge clk); gcnt++; end
            chk(gcnt == g, "R9 write spacing", gcnt, g);
            chk(cs_sel == 3'(2*ep[i]), "R1 cs_sel", cs_sel, 2*ep[i]);
            chk(cs_mask == NUM_CS'(3 << (2*ep[i])), "R1 cs_mask", cs_mask, 3 << (2*ep[i]));
            chk({bank[2], addr[2:0]} == 4'(en[i]), freq ? "R7 word" : "R2 word",
                {bank[2], addr[2:0]}, en[i]);
            chk({bank[1:0], addr[4:3]} == 4'(ev[i]),
                freq ? "R7 value" : (en[i] == 9 ? "R6 value" : "R5 value"),
                {bank[1:0], addr[4:3]}, ev[i]);
            chk(addr[ADDR_W-1:5] == '0, "R3 upper addr", addr[ADDR_W-1:5], 0);
            repeat (i % 3) @(negedge clk);
            chk(send_flag == 1'b1, "R4 flag held", send_flag, 1);
            issuer_clr = 1'b1;
            @(negedge clk);
            issuer_clr = 1'b0;
            chk(send_flag == 1'b0, "R4 flag cleared", send_flag, 0);
            gcnt = 0; p_prev = ep[i];
        end
        if (bad) dg = 1;
        else dg = ((p_prev < 0 && !freq) ? TS + TP : 0) + (freq ? 0 : TB) + NP - p_prev
                  + ((ep.size() == 0) ? 1 : 0) + ((poke && ep.size() == 0) ? 0 : 0);
        while (!done && gcnt < 3000) begin @(negedge clk); gcnt++; end
        chk(gcnt == dg, "R9 R10 done timing", gcnt, dg);
        chk(speed_err == bad, "R8 speed_err", speed_err, bad);
        chk(send_flag == 1'b0, "R8 R10 no write at end", send_flag, 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 single done, idle", {done, busy}, 0);
    endtask

    initial begin
        for (int d = 0; d < NP; d++)
            for (int s = 0; s < 5; s++) begin
                stv[d][s] = (d * 5 + s * 3 + 1) % 16;
                dimm_words[(d*5+s)*4 +: 4] = 4'(stv[d][s]);
            end
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && send_flag == 0 && speed_err == 0 && bank == 0
            && addr == 0 && cs_sel == 0 && cs_mask == 0, "R11 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        cs_present = 8'h03; dimm_sr = 4'b0001; pd_mode = 2'd1; vdd_code = 4'd5;
        run_pass(1'b0, 1'b0);
        cs_present = 8'h84; dimm_sr = 4'b0010; dimm_dr = 4'b1000; vdd_code = 4'd3;
        run_pass(1'b0, 1'b0);
        dimm_dr = 4'b0000; dimm_qr = 4'b0100;
        run_pass(1'b0, 1'b0);
        pd_mode = 2'd0;
        run_pass(1'b0, 1'b0);
        speed_grade = 12'd1866; cs_present = 8'h30;
        run_pass(1'b1, 1'b1);
        speed_grade = 12'd800;  cs_present = 8'hFF; run_pass(1'b1, 1'b0);
        speed_grade = 12'd1066; cs_present = 8'h0C; run_pass(1'b1, 1'b0);
        speed_grade = 12'd1333; run_pass(1'b1, 1'b0);
        speed_grade = 12'd1600; run_pass(1'b1, 1'b0);
        speed_grade = 12'd1000; run_pass(1'b1, 1'b0);
        cs_present = 8'h00; run_pass(1'b0, 1'b0);
        speed_grade = 12'd1600; run_pass(1'b1, 1'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule